// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial two-wire slave that exposes a small bank of 8-bit control registers to the rest of the chip. It watches the clock and data lines of an SMBus-style bus, answers to one fixed 7-bit device address, and pulls the data line low through an open-drain enable when it acknowledges or sends a zero. The full register contents are presented on a flat output vector so that neighbouring logic can use the settings directly.

A command code follows the address. Its top bit chooses between two kinds of access. In indexed mode, the low seven bits of the command name one register, and one byte is written to it or read from it. In sequential mode, the transfer runs from register 0 upward. A write carries a byte count ahead of its data. A read returns a byte count ahead of the register contents. Reads always begin with a write phase that carries the command, followed by a repeated START and the address with the read bit set.

The bus inputs pass through a flip-flop synchronizer, and every event is decoded from the synchronized copies. START and STOP can arrive at any moment. A STOP always sends the slave back to idle. A START always restarts address reception. In both cases any partly received byte is dropped.

Top module: `smb_regbank`

## Requirements
- R1: After reset the six registers (indices 0 to 5) hold 07h, FFh, 00h, 00h, 08h and 00h; reg_q carries register i in bits [8i+7:8i].
- R2: Only an address byte whose upper seven bits are 1101110 (write DCh, read DDh) is acknowledged. Any other address receives no acknowledge, and the rest of that transaction changes no register.
- R3: A command code with bit 7 = 1 selects indexed mode, and bits 6:0 give the register index. The following data byte is written to that register only. Bytes travel MSB first.
- R4: In indexed mode, a repeated START with the read address returns the indexed register's value MSB first.
- R5: A command code of 00h selects sequential mode. After the count byte, which is acknowledged and otherwise ignored, successive data bytes are written to registers 0, 1, 2 and so on. Bytes for indices 6 and above are acknowledged and discarded.
- R6: A sequential read first returns the count byte 06h, then registers 0, 1, 2 and so on. Any index of 6 or above reads 00h, and so does an indexed read of such an index.
- R7: The writable bit masks are: register 0 bits 7,6,2,1,0 (C7h); registers 1 and 2 bits 6,5,2,1 (66h); registers 3, 4 and 5 no bits. Non-writable bits keep their reset value.
- R8: A STOP after any complete byte ends the transfer and keeps the bytes already written. A STOP or START in the middle of a byte discards that byte, so nothing is written from it.
- R9: When the host answers a sent byte with NACK (data high), transmission stops and sda_oe stays low.
- R10: sda_oe changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| reg_q | output | NREG*8 | Current contents of all registers, register i in bits [8i+7:8i] |

## Verification
The hardest situations to reach are bus conditions that a well-behaved host rarely creates: a STOP or START that lands after only a few bits of a data byte, a sequential read that runs past the last register, and a NACK ending a read partway through. The bench drives the bus at bit level with its own master tasks, so it can cut a byte after any bit, issue a STOP with the data line pre-lowered, and choose ACK or NACK per byte. It mixes these directed cases with random indexed and sequential transfers whose offsets and lengths cross the end of the register bank.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } smb_st_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_BCNT,
    PH_DATA
  } smb_ph_e;

  // Power-up value of each register
  function automatic logic [BYTE_W-1:0] reg_dflt(input int idx);
    case (idx)
      0:       return 8'h07;
      1:       return 8'hFF;
      4:       return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  // Bits the host may change; everything else is reserved or read-only
  function automatic logic [BYTE_W-1:0] reg_wmask(input int idx);
    case (idx)
      0:       return 8'hC7;
      1, 2:    return 8'h66;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_N:0] scl_pipe;
  logic [SYNC_N:0] sda_pipe;
  logic            scl_p;
  logic            sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_N-1:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_N-1:0], sda_i};
    end
  end

  assign scl_s     = scl_pipe[SYNC_N-1];
  assign sda_s     = sda_pipe[SYNC_N-1];
  assign scl_p     = scl_pipe[SYNC_N];
  assign sda_p     = sda_pipe[SYNC_N];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_pkg::*;
#(
  parameter int NREG = 6,
  parameter int AW   = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [BYTE_W-1:0]      wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [BYTE_W-1:0]      rd_data,
  output logic [NREG*BYTE_W-1:0] reg_q
);
  logic [BYTE_W-1:0] q_r [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    localparam logic [BYTE_W-1:0] DFLT = reg_dflt(gi);
    localparam logic [BYTE_W-1:0] WM   = reg_wmask(gi);
    logic              we;
    logic [BYTE_W-1:0] q_n;

    assign we  = wr_en && (wr_addr == AW'(gi));
    assign q_n = (q_r[gi] & ~WM) | (wr_data & WM);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_r[gi] <= DFLT;
      else if (we) q_r[gi] <= q_n;
    end

    assign reg_q[gi*BYTE_W +: BYTE_W] = q_r[gi];

    AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((q_r[gi] & ~WM) == ($past(q_r[gi]) & ~WM))); // R7
    AST_WR_OTHER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != AW'(gi)) |=> $stable(q_r[gi])); // R3
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == AW'(i)) rd_data = q_r[i];
  end
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
#(
  parameter int           NREG     = 6,
  parameter int           AW       = 7,
  parameter logic [6:0]   DEV_ADDR = 7'h6E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [AW-1:0]     rd_addr,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(BYTE_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(BYTE_W - 1);

  smb_st_e           st, st_n;
  smb_ph_e           ph, ph_n;
  logic [CW-1:0]     cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic [BYTE_W-1:0] tx, tx_n;
  logic [AW-1:0]     ptr, ptr_n;
  logic              bc_pend, bc_n;
  logic              rdm, rdm_n;
  logic              mack, mack_n;
  logic              load;

  always_comb begin
    st_n   = st;
    ph_n   = ph;
    cnt_n  = cnt;
    sh_n   = sh;
    tx_n   = tx;
    ptr_n  = ptr;
    bc_n   = bc_pend;
    rdm_n  = rdm;
    mack_n = mack;
    wr_en  = 1'b0;
    load   = 1'b0;
    if (stop_det) begin
      st_n = ST_IDLE;
    end else if (start_det) begin
      st_n  = ST_RX;
      ph_n  = PH_ADDR;
      cnt_n = '0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise && cnt != CNT_FULL) begin
            sh_n  = {sh[BYTE_W-2:0], sda_s};
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_FULL) begin
            cnt_n = '0;
            st_n  = ST_RXACK;
            unique case (ph)
              PH_ADDR: begin
                if (sh[7:1] != DEV_ADDR) st_n = ST_IDLE;
                else begin
                  rdm_n = sh[0];
                  ph_n  = PH_CMD;
                end
              end
              PH_CMD: begin
                bc_n  = ~sh[7];
                ptr_n = sh[7] ? sh[AW-1:0] : '0;
                ph_n  = sh[7] ? PH_DATA : PH_BCNT;
              end
              PH_BCNT: ph_n = PH_DATA;
              PH_DATA: begin
                wr_en = 1'b1;
                ptr_n = ptr + 1'b1;
              end
            endcase
          end
        end
        ST_RXACK: begin
          if (scl_fall) begin
            if (rdm) begin
              st_n = ST_TX;
              load = 1'b1;
            end else begin
              st_n = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == CNT_LAST) begin
              st_n  = ST_TXACK;
              cnt_n = '0;
            end else begin
              tx_n  = {tx[BYTE_W-2:0], 1'b0};
              cnt_n = cnt + 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) mack_n = ~sda_s;
          else if (scl_fall) begin
            if (mack) begin
              st_n = ST_TX;
              load = 1'b1;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
    if (load) begin
      if (bc_pend) begin
        tx_n = BYTE_W'(NREG);
        bc_n = 1'b0;
      end else begin
        tx_n  = rd_data;
        ptr_n = ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph      <= PH_ADDR;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      ptr     <= '0;
      bc_pend <= 1'b0;
      rdm     <= 1'b0;
      mack    <= 1'b0;
    end else begin
      st      <= st_n;
      ph      <= ph_n;
      cnt     <= cnt_n;
      sh      <= sh_n;
      tx      <= tx_n;
      ptr     <= ptr_n;
      bc_pend <= bc_n;
      rdm     <= rdm_n;
      mack    <= mack_n;
    end
  end

  assign rd_addr = ptr;
  assign wr_addr = ptr;
  assign wr_data = sh;
  assign sda_oe  = (st == ST_RXACK) | ((st == ST_TX) & ~tx[BYTE_W-1]);

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE && !sda_oe)); // R8
  AST_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (st == ST_RX && ph == PH_ADDR && cnt == '0)); // R8
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R10
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TXACK && scl_fall && !mack && !start_det && !stop_det) |=> (st == ST_IDLE && !sda_oe)); // R9
  AST_FOREIGN_NOACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX && ph == PH_ADDR && cnt == CNT_FULL && scl_fall && !start_det && !stop_det
     && sh[7:1] != DEV_ADDR) |=> (st == ST_IDLE && !sda_oe)); // R2
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smb_pkg::*;
#(
  parameter int         NREG     = 6,
  parameter int         SYNC_N   = 2,
  parameter logic [6:0] DEV_ADDR = 7'h6E
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  output logic [NREG*BYTE_W-1:0] reg_q
);
  localparam int AW = 7;

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  smb_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_ctrl #(.NREG(NREG), .AW(AW), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  smb_regfile #(.NREG(NREG), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .reg_q(reg_q)
  );
endmodule

// File: tb/smb_regbank_tb.sv
`timescale 1ns/1ps
module smb_regbank_tb_top;
  localparam int NREG = 6;
  localparam int Q    = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              scl_m = 1'b1;
  logic              sda_m = 1'b1;
  logic              sda_oe;
  logic              sda_line;
  logic [NREG*8-1:0] reg_q;

  assign sda_line = sda_m & ~sda_oe;

  smb_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_q(reg_q)
  );

  int   n_chk = 0;
  int   n_fail = 0;
  int   r10_viol = 0;
  bit   done = 1'b0;
  logic oe_prev = 1'b0;
  logic [7:0] mdl [NREG];

  // R10 monitor: data enable may move only while the host holds the clock low
  always @(negedge clk) begin
    if (sda_oe !== oe_prev && scl_m) r10_viol++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] dflt(input int i);
    case (i) 0: return 8'h07; 1: return 8'hFF; 4: return 8'h08; default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] wmask(input int i);
    case (i) 0: return 8'hC7; 1, 2: return 8'h66; default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] exp_rd(input int i);
    return (i < NREG) ? mdl[i] : 8'h00;
  endfunction
  function automatic void mdl_wr(input int i, input logic [7:0] d);
    if (i < NREG) mdl[i] = (mdl[i] & ~wmask(i)) | (d & wmask(i));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, expv);
    end
  endtask
  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++) check(req, reg_q[i*8 +: 8], mdl[i]);
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_line; qw(); scl_m = 1'b0; qw();
  endtask
  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(nb);
    ack = ~nb;
  endtask
  task automatic get_byte(output logic [7:0] d, input logic nack);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(nack);
  endtask

  task automatic byte_write(input int off, input logic [7:0] d, input string req);
    logic a;
    bus_start();
    put_byte(8'hDC, a); check(req, 8'(a), 8'h01);
    put_byte({1'b1, 7'(off)}, a); check(req, 8'(a), 8'h01);
    put_byte(d, a); check(req, 8'(a), 8'h01);
    bus_stop();
    mdl_wr(off, d);
  endtask

  task automatic byte_read(input int off, input string req);
    logic a; logic [7:0] d;
    bus_start();
    put_byte(8'hDC, a);
    put_byte({1'b1, 7'(off)}, a);
    bus_start();
    put_byte(8'hDD, a); check(req, 8'(a), 8'h01);
    get_byte(d, 1'b1);
    check(req, d, exp_rd(off));
    bus_stop();
  endtask

  task automatic block_write(input int n, input string req);
    logic a; logic [7:0] d;
    bus_start();
    put_byte(8'hDC, a);
    put_byte(8'h00, a); check(req, 8'(a), 8'h01);
    put_byte(8'(n), a); check(req, 8'(a), 8'h01);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      put_byte(d, a); check(req, 8'(a), 8'h01);
      mdl_wr(k, d);
    end
    bus_stop();
  endtask

  task automatic block_read(input int n, input string req);
    logic a; logic [7:0] d;
    bus_start();
    put_byte(8'hDC, a);
    put_byte(8'h00, a);
    bus_start();
    put_byte(8'hDD, a); check(req, 8'(a), 8'h01);
    get_byte(d, 1'b0);
    check(req, d, 8'h06);
    for (int k = 0; k < n; k++) begin
      get_byte(d, (k == n - 1));
      check(req, d, exp_rd(k));
    end
    check("R9", 8'(sda_oe), 8'h00);
    bus_stop();
  endtask

  initial begin
    logic a; logic [7:0] d;
    void'($urandom(32'h5EED_0123));
    for (int i = 0; i < NREG; i++) mdl[i] = dflt(i);
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check_regs("R1");
    check("R1", 8'(sda_oe), 8'h00);

    // R2: foreign address is not acknowledged and writes nothing
    bus_start();
    put_byte(8'hA0, a); check("R2", 8'(a), 8'h00);
    put_byte(8'h81, a); put_byte(8'h00, a);
    bus_stop();
    check_regs("R2");

    // R3/R7: indexed write of zeros into register 1
    byte_write(1, 8'h00, "R3");
    check("R7", reg_q[15:8], 8'h99);
    byte_read(1, "R4");
    // R7: read-only register ignores writes
    byte_write(4, 8'h55, "R7");
    check("R7", reg_q[39:32], 8'h08);
    byte_read(4, "R4");
    byte_write(0, 8'hFF, "R7");
    check_regs("R7");

    // R5: sequential write of all six plus two extra
    block_write(8, "R5");
    check_regs("R5");
    // R6: sequential read past the end
    block_read(8, "R6");
    byte_read(7, "R6");

    // R8: STOP after four data bits, nothing written
    bus_start();
    put_byte(8'hDC, a); put_byte(8'h82, a);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    check_regs("R8");
    // R8: START in mid-byte, then a fresh valid write
    bus_start();
    put_byte(8'hDC, a); put_byte(8'h81, a);
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    bus_start();
    put_byte(8'hDC, a); check("R8", 8'(a), 8'h01);
    put_byte(8'h82, a); put_byte(8'h24, a);
    bus_stop();
    mdl_wr(2, 8'h24);
    check_regs("R8");
    // R8: sequential write stopped after two data bytes
    block_write(2, "R8");
    check_regs("R8");

    // Random mix
    for (int it = 0; it < 20; it++) begin
      case ($urandom_range(3, 0))
        0: begin byte_write(int'($urandom_range(7, 0)), 8'($urandom), "R3"); check_regs("R3"); end
        1: byte_read(int'($urandom_range(7, 0)), "R4");
        2: begin block_write(int'($urandom_range(8, 0)), "R5"); check_regs("R5"); end
        default: block_read(int'($urandom_range(8, 1)), "R6");
      endcase
    end

    check("R10", 8'(r10_viol), 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule